// File: doc/BRIEF.md
# Single-Slope Fast PWM Generator

This block is an 8-bit up-counting timer that drives one pulse-width-modulated output. A count-enable strobe comes from a small divider with five selectable ratios. The counter climbs from zero to a ceiling and then returns to zero. The ceiling is either the full count of 255 or the active compare value. Software writes a new compare value into a holding register. That value becomes active only at the wrap, so a period never sees a half-applied duty change.

The output is produced by a three-state waveform machine: `WV_OFF`, `WV_LOW` and `WV_HIGH`. The state register is the output flop, and the output is high only in `WV_HIGH`.

The transitions are:
- `OFF->LOW` when the mode becomes non-zero.
- `any->OFF` when the mode is zero.
- `LOW->HIGH` on a set event.
- `HIGH->LOW` on a clear event.
- `LOW<->HIGH` on a toggle event.

Which counter event sets, clears or toggles depends on the two-bit output mode. With the mode set, the block gives a square wave, a non-inverted PWM or an inverted PWM.

Top module: `fpwm_gen`

## Requirements
- R1: A synchronous reset clears the counter, the holding and active compare registers, the divider phase and the output, and puts the waveform machine in `WV_OFF`.
- R2: While `run` is high the counter steps once every N clocks, where `div_sel` 0,1,2,3,4 selects N = 1,8,64,256,1024 and codes 5 to 7 also select 1024. The first step comes on the Nth clock edge after `run` rises. While `run` is low the counter holds and the divider phase returns to zero.
- R3: On each step the counter goes to count+1, or to 0 when count is at or above the ceiling. The ceiling is 255 when `top_sel`=0 and the active compare value when `top_sel`=1.
- R4: A `cmp_wr` pulse loads only the holding register. The active compare value takes the holding value on a step that wraps the counter, and at no other time.
- R5: In mode 2 (non-inverting), once the machine has left `WV_OFF`, a wrapping step drives the output to 1. Otherwise a step taken while count equals the active compare value drives it to 0. With ceiling 255 the output is high for compare+1 steps out of every 256.
- R6: In mode 3 (inverting) the two levels of R5 are swapped, so the output is high for 255−compare steps out of every 256.
- R7: With ceiling 255 in mode 2, a compare value of 0 gives a pulse one step wide every 256 steps. A compare value of 255 gives a constant 1, because the wrap takes priority over the match.
- R8: In mode 1 (toggle) the output inverts on every step taken while count equals the active compare value. With ceiling 255 this is once every 256 steps. With `top_sel`=1, compare 0 and N=1 it inverts on every clock.
- R9: In mode 0 the output is 0 on the following clock. On leaving mode 0 the output starts at 0, and counter events in that first clock are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the divider and counter |
| div_sel | input | 3 | Divide ratio select |
| top_sel | input | 1 | Ceiling select: 0 = 255, 1 = active compare |
| out_mode | input | 2 | 0 off, 1 toggle, 2 non-inverting, 3 inverting |
| cmp_wr | input | 1 | Write strobe for the holding compare register |
| cmp_wdata | input | 8 | Compare value to write |
| cnt_out | output | 8 | Current counter value |
| wave_out | output | 1 | Registered waveform output |

## Verification
The duty cycle is measured over whole periods for compare values of 0, 100, 200 and 255 in both polarities. These runs separate the match edge from the wrap edge and check that the wrap wins when the two coincide. A compare write placed in the middle of a period is then probed at a fixed count before and after the next wrap, which shows whether the holding register is bypassed.

Counter rates are measured with the divider at 8 and at 64, both after a pause in `run`. This exposes a wrong divider ratio or divider phase. Toggle mode is run with both ceilings, and a small compare value is used as the ceiling. These runs check the square-wave rate and the wrap at a reduced ceiling. A cycle-by-cycle behavioural model is compared throughout.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_TOGGLE = 2'd1,
        MODE_NONINV = 2'd2,
        MODE_INV    = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        WV_OFF,
        WV_LOW,
        WV_HIGH
    } wave_state_e;

    // log2 of divide ratio for each select code
    function automatic int unsigned div_log2(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 3;
            3'd2:    return 6;
            3'd3:    return 8;
            default: return 10;
        endcase
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] div_sel,
    output logic       tick
);
    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = PRE_W'((1 << pwm_pkg::div_log2(div_sel)) - 1);
        tick  = run && (phase >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             top_sel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp_act,
    output logic             wrap_ev,
    output logic             match_ev
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cmp_hold;
    logic [CNT_W-1:0] ceiling;

    always_comb begin
        ceiling  = top_sel ? cmp_act : CNT_MAX;
        wrap_ev  = tick && (cnt >= ceiling);
        match_ev = tick && (cnt == cmp_act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            cmp_act  <= '0;
            cmp_hold <= '0;
        end else begin
            if (wrap_ev) begin
                cnt     <= '0;
                cmp_act <= cmp_hold;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
            if (cmp_wr) begin
                cmp_hold <= cmp_wdata;
            end
        end
    end
endmodule

// File: rtl/pwm_wave_fsm.sv
module pwm_wave_fsm
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] out_mode,
    input  logic       wrap_ev,
    input  logic       match_ev,
    output logic       wave,
    output logic       live
);
    wave_state_e state, state_nx;
    out_mode_e   mode;
    logic        set_ev, clr_ev, tog_ev;

    always_comb begin
        mode   = out_mode_e'(out_mode);
        set_ev = 1'b0;
        clr_ev = 1'b0;
        tog_ev = 1'b0;
        unique case (mode)
            MODE_OFF:    ;
            MODE_TOGGLE: tog_ev = match_ev;
            MODE_NONINV: begin
                set_ev = wrap_ev;
                clr_ev = match_ev && !wrap_ev;
            end
            MODE_INV: begin
                clr_ev = wrap_ev;
                set_ev = match_ev && !wrap_ev;
            end
        endcase

        state_nx = state;
        if (mode == MODE_OFF) begin
            state_nx = WV_OFF;
        end else begin
            unique case (state)
                WV_OFF:  state_nx = WV_LOW;
                WV_LOW:  if (set_ev || tog_ev) state_nx = WV_HIGH;
                WV_HIGH: if (clr_ev || tog_ev) state_nx = WV_LOW;
                default: state_nx = WV_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WV_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        wave = (state == WV_HIGH);
        live = (state != WV_OFF);
    end
endmodule

// File: rtl/fpwm_gen.sv
module fpwm_gen #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [2:0]       div_sel,
    input  logic             top_sel,
    input  logic [1:0]       out_mode,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt_out,
    output logic             wave_out
);
    logic             tick;
    logic [CNT_W-1:0] cmp_act;
    logic             wrap_ev, match_ev, wave_live;

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .run(run), .div_sel(div_sel), .tick(tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst(rst), .tick(tick), .top_sel(top_sel),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt(cnt_out),
        .cmp_act(cmp_act), .wrap_ev(wrap_ev), .match_ev(match_ev)
    );

    pwm_wave_fsm u_fsm (
        .clk(clk), .rst(rst), .out_mode(out_mode), .wrap_ev(wrap_ev),
        .match_ev(match_ev), .wave(wave_out), .live(wave_live)
    );
endmodule

// File: rtl/fpwm_gen_chk.sv
module fpwm_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             top_sel,
    input logic [1:0]       out_mode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_act,
    input logic             wave,
    input logic             live
);
    logic [CNT_W-1:0] ceil_c;
    logic             wraps;
    assign ceil_c = top_sel ? cmp_act : {CNT_W{1'b1}};
    assign wraps  = tick && (cnt >= ceil_c);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0) && !wave && (cmp_act == '0));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !wraps) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        wraps |=> cnt == '0);

    assert_cmp_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !wraps |=> $stable(cmp_act));

    assert_noninv_set_R5: assert property (@(posedge clk) disable iff (rst)
        (wraps && live && out_mode == 2'd2) |=> wave);

    assert_inv_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wraps && live && out_mode == 2'd3) |=> !wave);

    assert_off_low_R9: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 2'd0) |=> !wave);
endmodule

bind fpwm_gen fpwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .top_sel(top_sel),
    .out_mode(out_mode), .cnt(cnt_out), .cmp_act(cmp_act),
    .wave(wave_out), .live(wave_live)
);

// File: tb/sim_fpwm_gen.sv
`timescale 1ns/1ps
module sim_fpwm_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       top_sel = 1'b0;
    logic [1:0] out_mode = 2'd0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic [7:0] cnt_out;
    logic       wave_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_pc = 0, m_cnt = 0, m_hold = 0, m_act = 0, m_st = 0; // st: 0 off,1 low,2 high

    always #2.5 clk = ~clk;

    fpwm_gen u0 (
        .clk(clk), .rst(rst), .run(run), .div_sel(div_sel), .top_sel(top_sel),
        .out_mode(out_mode), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cnt_out(cnt_out), .wave_out(wave_out)
    );

    function automatic int ratio(input int code);
        case (code)
            0: return 1;
            1: return 8;
            2: return 64;
            3: return 256;
            default: return 1024;
        endcase
    endfunction

    always @(posedge clk) begin
        int  lim, top;
        bit  tk, wr, mt;
        cycles++;
        if (rst) begin
            m_pc = 0; m_cnt = 0; m_hold = 0; m_act = 0; m_st = 0;
        end else begin
            lim = ratio(int'(div_sel)) - 1;
            tk  = run && (m_pc >= lim);
            if (!run || tk) m_pc = 0; else m_pc = m_pc + 1;
            top = top_sel ? m_act : 255;
            wr  = tk && (m_cnt >= top);
            mt  = tk && (m_cnt == m_act);
            if (out_mode == 2'd0) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else if (out_mode == 2'd1) begin
                if (mt) m_st = (m_st == 2) ? 1 : 2;
            end else if (out_mode == 2'd2) begin
                if (wr) m_st = 2; else if (mt) m_st = 1;
            end else begin
                if (wr) m_st = 1; else if (mt) m_st = 2;
            end
            if (wr) begin m_cnt = 0; m_act = m_hold; end
            else if (tk) m_cnt = m_cnt + 1;
            if (cmp_wr) m_hold = int'(cmp_wdata);
        end
    end

    always @(negedge clk) begin
        checks++;
        if (int'(cnt_out) != m_cnt || wave_out != (m_st == 2)) begin
            failures++;
            $display("FAIL %s model cycle %0d: cnt=%0d wave=%0b expected cnt=%0d wave=%0b",
                     cur_req, cycles, cnt_out, wave_out, m_cnt, (m_st == 2));
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (int'(cnt_out) != v);
    endtask

    task automatic write_cmp(input int v);
        cmp_wdata = 8'(v);
        cmp_wr = 1'b1;
        cyc(1);
        cmp_wr = 1'b0;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wave_out) hi++;
        end
    endtask

    task automatic count_edges(input int n, output int ed);
        logic prev;
        ed = 0;
        prev = wave_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wave_out != prev) ed++;
            prev = wave_out;
        end
    endtask

    task automatic load_cmp(input int v);
        write_cmp(v);
        wait_cnt(255);
        wait_cnt(3);
    endtask

    initial begin
        int r;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R1 reset cnt", int'(cnt_out), 0);
        check("R1 reset wave", int'(wave_out), 0);

        cur_req = "R2";
        div_sel = 3'd1; run = 1'b1;
        cyc(80);
        check("R2 div8 steps", int'(cnt_out), 10);
        run = 1'b0;
        cyc(20);
        check("R2 hold while stopped", int'(cnt_out), 10);
        div_sel = 3'd2; run = 1'b1;
        cyc(640);
        check("R2 div64 steps", int'(cnt_out), 20);
        run = 1'b0;

        rst = 1'b1; cyc(2); rst = 1'b0;
        cur_req = "R5";
        write_cmp(100);
        out_mode = 2'd2; div_sel = 3'd0; run = 1'b1;
        wait_cnt(255); wait_cnt(5);
        count_high(256, r);
        check("R5 noninv duty cmp100", r, 101);

        cur_req = "R4";
        wait_cnt(10);
        write_cmp(200);
        wait_cnt(150);
        check("R4 old compare still active", int'(wave_out), 0);
        wait_cnt(255); wait_cnt(150);
        check("R4 new compare after wrap", int'(wave_out), 1);

        cur_req = "R6";
        out_mode = 2'd3;
        wait_cnt(255); wait_cnt(3);
        count_high(256, r);
        check("R6 inv duty cmp200", r, 55);

        cur_req = "R7";
        out_mode = 2'd2;
        load_cmp(0);
        count_high(256, r);
        check("R7 spike cmp0", r, 1);
        load_cmp(255);
        count_high(256, r);
        check("R7 constant cmp255", r, 256);

        cur_req = "R8";
        out_mode = 2'd1;
        load_cmp(50);
        count_edges(512, r);
        check("R8 toggle ceiling255", r, 2);
        load_cmp(0);
        top_sel = 1'b1;
        cyc(2);
        count_edges(16, r);
        check("R8 toggle every clock", r, 16);

        cur_req = "R3";
        write_cmp(9);
        cyc(30);
        begin
            int mx = 0;
            bit saw_wrap = 0;
            int prev = int'(cnt_out);
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (int'(cnt_out) > mx) mx = int'(cnt_out);
                if (prev == 9 && cnt_out == 8'd0) saw_wrap = 1;
                prev = int'(cnt_out);
            end
            check("R3 ceiling from compare", mx, 9);
            check("R3 wrap to zero", int'(saw_wrap), 1);
        end

        cur_req = "R9";
        out_mode = 2'd0;
        cyc(1);
        count_high(300, r);
        check("R9 mode off holds low", r, 0);
        top_sel = 1'b0;
        out_mode = 2'd2;
        cyc(1);
        check("R9 first clock after off", int'(wave_out), 0);
        cyc(600);
        summary();
    end
endmodule